// File: doc/BRIEF.md
# Pipelined Loadable Up/Down Counter

A synchronous binary counter for a fast clock. It counts up or down, loads a parallel value, clears to zero, and holds when not enabled. Every control input is captured in a register before it reaches the count logic, so no pin drives the counter combinationally. The count is split into a low half and a high half. The carry or borrow leaving the low half is registered before it steps the high half, so the carry chain is only half as long per cycle.

The low half is delayed by one stage on its way to the output, and load and clear reach the high half one stage later. Because of this, `count_o` always shows a consistent full-width value. A control sampled at a clock edge shows on `count_o` after the second edge that follows, at every width. The load selection sits in front of the low-half register, and the wrap detection reads only the present low-half value, so the load mux is not in series with the carry.

Top module: `pipe_updown_ctr`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and `out_valid_o` is 0.
- R2: With `en_i`=1 and `up_i`=1, the count rises by one for each sampled cycle and wraps from 2^WIDTH-1 to 0.
- R3: With `en_i`=1 and `up_i`=0, the count falls by one for each sampled cycle and wraps from 0 to 2^WIDTH-1.
- R4: With `en_i`=0, `clr_i`=0 and `load_i`=0, the count holds whatever the value of `up_i`.
- R5: `load_i`=1 replaces the full count with `load_value_i`.
- R6: `clr_i` wins over `load_i`, and `load_i` wins over counting.
- R7: Latency is fixed. A control sampled at a rising edge changes `count_o` right after the second rising edge that follows, and `count_o` does not change before that.
- R8: A wrap of the low half shows on `count_o` in a single step, with both halves updated together; for example 0x00FF counting up goes straight to 0x0100.
- R9: The registered carry keeps the direction that was in force when it was generated: 0x00FF, up once and then down once, gives 0x0100 and then 0x00FF.
- R10: `out_valid_o` goes high right after the third rising edge after reset is released, and stays high.
- R11: A load or clear in the cycle after a low-half wrap cancels the pending carry, so the loaded value is not stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| clr_i | input | 1 | Synchronous clear |
| load_i | input | 1 | Parallel load |
| load_value_i | input | WIDTH | Value to load |
| count_o | output | WIDTH | Counter value |
| out_valid_o | output | 1 | High once the pipeline holds registered controls |

## Verification
The bench builds the block at its default WIDTH of 16, which gives two 8-bit halves. At that size a low-half wrap happens every 256 counts, so the bench can set up a wrap from a nearby value with a load. The bench crosses both halves in each direction (0x00FD to 0x0103 and 0x0101 to 0x00FE) and checks every cycle that the output moves by at most one. It also reaches the full-width wraps from 0xFFFE and from 0x0001, and it aims loads and direction reversals at the exact cycle in which a carry is still pending.

// File: rtl/pipe_updown_pkg.sv
package pipe_updown_pkg;
  typedef struct packed {
    logic clr;
    logic load;
    logic en;
    logic up;
  } ctrl_t;
endpackage

// File: rtl/pipe_updown_ctrl_stage.sv
module pipe_updown_ctrl_stage
  import pipe_updown_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_value_i,
  output ctrl_t            ctrl_o,
  output logic [WIDTH-1:0] value_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      value_o <= '0;
    end else begin
      ctrl_o  <= '{clr: clr_i, load: load_i, en: en_i, up: up_i};
      value_o <= load_value_i;
    end
  end
endmodule

// File: rtl/pipe_updown_low_half.sv
module pipe_updown_low_half
  import pipe_updown_pkg::*;
#(
  parameter int unsigned HALF = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctrl_t           ctrl_i,
  input  logic [HALF-1:0] value_i,
  output logic [HALF-1:0] lo_dly_o,
  output logic            cy_o,
  output logic            cy_up_o
);
  logic [HALF-1:0] lo_q, lo_step, lo_nxt;
  logic            wrap_hit;

  // load select feeds the register; wrap detect reads only lo_q
  always_comb begin
    lo_step = ctrl_i.up ? lo_q + 1'b1 : lo_q - 1'b1;
    if (ctrl_i.clr)       lo_nxt = '0;
    else if (ctrl_i.load) lo_nxt = value_i;
    else if (ctrl_i.en)   lo_nxt = lo_step;
    else                  lo_nxt = lo_q;
    wrap_hit = ctrl_i.en && !ctrl_i.clr && !ctrl_i.load &&
               (ctrl_i.up ? (&lo_q) : ~(|lo_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      lo_dly_o <= '0;
      cy_o     <= 1'b0;
      cy_up_o  <= 1'b0;
    end else begin
      lo_q     <= lo_nxt;
      lo_dly_o <= lo_q;
      cy_o     <= wrap_hit;
      cy_up_o  <= ctrl_i.up;
    end
  end
endmodule

// File: rtl/pipe_updown_high_half.sv
module pipe_updown_high_half
  import pipe_updown_pkg::*;
#(
  parameter int unsigned HALF = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctrl_t           ctrl_i,
  input  logic [HALF-1:0] value_i,
  input  logic            cy_i,
  input  logic            cy_up_i,
  output logic [HALF-1:0] hi_o
);
  logic            clr_d, load_d;
  logic [HALF-1:0] value_d;

  // load/clear delayed one stage to line up with the delayed low half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_d   <= 1'b0;
      load_d  <= 1'b0;
      value_d <= '0;
      hi_o    <= '0;
    end else begin
      clr_d   <= ctrl_i.clr;
      load_d  <= ctrl_i.load;
      value_d <= value_i;
      if (clr_d)       hi_o <= '0;
      else if (load_d) hi_o <= value_d;
      else if (cy_i)   hi_o <= cy_up_i ? hi_o + 1'b1 : hi_o - 1'b1;
    end
  end
endmodule

// File: rtl/pipe_updown_ctr.sv
module pipe_updown_ctr
  import pipe_updown_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_value_i,
  output logic [WIDTH-1:0] count_o,
  output logic             out_valid_o
);
  localparam int unsigned HALF     = WIDTH / 2;
  localparam int unsigned FILL_LEN = 3;

  ctrl_t                ctrl_q;
  logic [WIDTH-1:0]     value_q;
  logic [HALF-1:0]      lo_dly, hi;
  logic                 cy, cy_up;
  logic [FILL_LEN-1:0]  fill_q;

  pipe_updown_ctrl_stage #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .up_i, .clr_i, .load_i, .load_value_i,
    .ctrl_o(ctrl_q), .value_o(value_q)
  );

  pipe_updown_low_half #(.HALF(HALF)) u_lo (
    .clk_i, .rst_ni, .ctrl_i(ctrl_q), .value_i(value_q[HALF-1:0]),
    .lo_dly_o(lo_dly), .cy_o(cy), .cy_up_o(cy_up)
  );

  pipe_updown_high_half #(.HALF(HALF)) u_hi (
    .clk_i, .rst_ni, .ctrl_i(ctrl_q), .value_i(value_q[WIDTH-1:HALF]),
    .cy_i(cy), .cy_up_i(cy_up), .hi_o(hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= {fill_q[FILL_LEN-2:0], 1'b1};
  end

  assign count_o     = {hi, lo_dly};
  assign out_valid_o = fill_q[FILL_LEN-1];
endmodule

// File: rtl/pipe_updown_ctr_chk.sv
module pipe_updown_ctr_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             up_i,
  input logic             clr_i,
  input logic             load_i,
  input logic [WIDTH-1:0] load_value_i,
  input logic [WIDTH-1:0] count_o,
  input logic             out_valid_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_STATE: assert (count_o == '0 && !out_valid_o); // R1
    end
  end

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && !load_i && !clr_i) |=> ##2
    (count_o == WIDTH'($past(count_o) + 1'b1))); // R2

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !up_i && !load_i && !clr_i) |=> ##2
    (count_o == WIDTH'($past(count_o) - 1'b1))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && !clr_i) |=> ##2 $stable(count_o)); // R4

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> ##2 (count_o == $past(load_value_i, 3))); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ##2 (count_o == '0)); // R6

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> out_valid_o); // R10
endmodule

bind pipe_updown_ctr pipe_updown_ctr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .up_i(up_i), .clr_i(clr_i),
  .load_i(load_i), .load_value_i(load_value_i), .count_o(count_o),
  .out_valid_o(out_valid_o)
);

// File: tb/pipe_updown_ctr_tb.sv
module pipe_updown_ctr_tb;
  localparam int unsigned WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en = 1'b0, up = 1'b0, clr = 1'b0, load = 1'b0;
  logic [WIDTH-1:0] load_value = '0;
  logic [WIDTH-1:0] count;
  logic             out_valid;
  int               n_chk = 0;
  int               n_err = 0;
  bit               done = 1'b0;

  always #5 clk = ~clk;

  pipe_updown_ctr #(.WIDTH(WIDTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .up_i(up), .clr_i(clr),
    .load_i(load), .load_value_i(load_value), .count_o(count),
    .out_valid_o(out_valid)
  );

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [WIDTH-1:0] v);
    load = 1'b1; load_value = v; cyc();
    load = 1'b0; cyc(3);
  endtask

  // run k enabled cycles, check single steps every cycle
  task automatic run(input string tag, input logic dir, input int k,
                     input logic [WIDTH-1:0] exp_end);
    logic [WIDTH-1:0] prev;
    int bad;
    bad = 0;
    prev = count;
    en = 1'b1; up = dir;
    for (int i = 0; i < k + 3; i++) begin
      if (i == k) en = 1'b0;
      cyc();
      if (count != prev && count != (dir ? prev + 1'b1 : prev - 1'b1)) bad++;
      prev = count;
    end
    chk({tag, " single-step"}, WIDTH'(bad), '0);
    chk({tag, " end value"}, count, exp_end);
  endtask

  task automatic t_reset; // R1 R10
    cyc(2);
    chk("R1 count in reset", count, '0);
    chk("R1 valid in reset", {15'd0, out_valid}, 16'd0);
    rst_ni = 1'b1;
    cyc(2);
    chk("R10 valid low after 2 edges", {15'd0, out_valid}, 16'd0);
    cyc();
    chk("R10 valid high after 3 edges", {15'd0, out_valid}, 16'd1);
  endtask

  task automatic t_latency; // R5 R7
    load = 1'b1; load_value = 16'h1234; cyc();
    load = 1'b0;
    cyc();
    chk("R7 no change after 1 edge", count, '0);
    cyc();
    chk("R7 R5 load after 2 edges", count, 16'h1234);
  endtask

  task automatic t_hold; // R4
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin up = i[0]; cyc(); end
    cyc(3);
    chk("R4 hold with enable low", count, 16'h1234);
  endtask

  task automatic t_counting; // R2 R3 R8
    run("R2 up", 1'b1, 5, 16'h1239);
    do_load(16'h00FD);
    run("R8 up across halves", 1'b1, 6, 16'h0103);
    do_load(16'hFFFE);
    run("R2 wrap up", 1'b1, 3, 16'h0001);
    do_load(16'h0101);
    run("R3 R8 down across halves", 1'b0, 3, 16'h00FE);
    do_load(16'h0001);
    run("R3 wrap down", 1'b0, 2, 16'hFFFF);
  endtask

  task automatic t_reverse; // R9
    do_load(16'h00FF);
    en = 1'b1; up = 1'b1; cyc();
    up = 1'b0; cyc();
    en = 1'b0;
    cyc();
    chk("R9 after up step", count, 16'h0100);
    cyc();
    chk("R9 after down step", count, 16'h00FF);
    cyc(3);
    chk("R9 settled", count, 16'h00FF);
  endtask

  task automatic t_priority; // R6
    do_load(16'h4000);
    clr = 1'b1; load = 1'b1; load_value = 16'hABCD; en = 1'b1; up = 1'b1; cyc();
    clr = 1'b0; load = 1'b0; en = 1'b0; cyc(3);
    chk("R6 clear over load", count, 16'h0000);
    load = 1'b1; load_value = 16'h0F0F; en = 1'b1; up = 1'b0; cyc();
    load = 1'b0; en = 1'b0; cyc(3);
    chk("R6 load over count", count, 16'h0F0F);
    en = 1'b1; up = 1'b1; cyc(3);
    clr = 1'b1; cyc();
    clr = 1'b0; en = 1'b0; cyc(3);
    chk("R6 clear during count", count, 16'h0000);
  endtask

  task automatic t_cancel; // R11
    do_load(16'h00FF);
    en = 1'b1; up = 1'b1; cyc();
    en = 1'b0; load = 1'b1; load_value = 16'h5555; cyc();
    load = 1'b0; cyc(5);
    chk("R11 load cancels carry", count, 16'h5555);
    do_load(16'h0000);
    en = 1'b1; up = 1'b0; cyc();
    en = 1'b0; clr = 1'b1; cyc();
    clr = 1'b0; cyc(5);
    chk("R11 clear cancels borrow", count, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_hold();
    t_counting();
    t_reverse();
    t_priority();
    t_cancel();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule